// File: doc/BRIEF.md
# Chip select and access classifier

This block sits on the external bus request path and decides where each request goes. Every request address is compared against a set of programmable chip-select regions and a set of memory-controller (DRAM) regions. The block then reports whether the access belongs to one chip select, to one DRAM region, or to the default external space. It drives the matching active-low chip-select line and gives the static port size and burst permission that go with the access. Combinations that the hit table leaves undefined are flagged and never resolved silently.

Each region has a base register, a mask register whose bit 0 is the region's valid bit, and a small control register holding a 2-bit port-size code and a burst-enable bit. Software writes these through a plain address/data/strobe port. Chip select 0 serves as the boot select. From reset until its valid bit is first written to 1, it claims every request regardless of address, and all other regions stay silent. All decode results are registered, so they appear one clock after the request.

Top module: `cs_access_classifier`

## Requirements
- R1: While reset is held and after it is released, `cs_n_o` is all ones, `kind_o` is 0 (idle), `undef_o` is 0 and all attribute outputs are 0. Every valid bit is clear after reset.
- R2: From reset until a write puts 1 into bit 0 of chip select 0's mask register, every request drives only `cs_n_o[0]` low, with `kind_o`=1 and `undef_o`=0. The attributes come from chip select 0's control register. The request address and all other regions have no effect.
- R3: Once chip select 0's valid bit has been written to 1, the boot override ends for good. Chip select 0 then decodes by its own base and mask like every other region, and clearing its valid bit later does not bring the override back.
- R4: A region hits when its valid bit (mask bit 0) is 1 and the request address equals the base on every bit position from 1 upward whose mask bit is 0. Address bit 0 is never compared.
- R5: With no chip-select hit and no DRAM hit, the access is default external: `kind_o`=3, `port_size_o`=00, `bus_bytes_o`=4, `burst_en_o`=0, and all chip selects are high.
- R6: With exactly one chip-select hit and no DRAM hit, `kind_o`=1 and only that chip select's `cs_n_o` bit is low. `port_size_o` is control bits [1:0] and `burst_en_o` is control bit 2. `bus_bytes_o` decodes the port size as 00→4, 01→1, 10→2, 11→4.
- R7: With no chip-select hit and exactly one DRAM hit, `kind_o`=2 and `dram_idx_o` gives the region index. Port size, byte width and burst come from that DRAM region's control register in the same encoding. All chip selects stay high.
- R8: Two or more chip-select hits, two or more DRAM hits, or at least one of each, set `undef_o`=1 with `kind_o`=0, all chip selects high and all attributes 0.
- R9: A cycle without `req_valid` gives idle outputs on the next clock: all chip selects high, `kind_o`=0, `undef_o`=0.
- R10: Outputs for a request appear one clock after it. A register write takes effect on requests in the following cycle, so a request in the same cycle as a write still sees the old value.
- R11: `wr_addr` is {region, field}. Regions 0 to 3 are chip selects and 4 to 5 are DRAM regions. Field 0 is base, 1 is mask, 2 is control. Writes to field 3 or to region numbers above 5 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register select {region, field} |
| wr_data | input | 32 | Register write data |
| req_valid | input | 1 | External bus request present |
| req_addr | input | 32 | Request address |
| cs_n_o | output | 4 | Chip selects, active low, at most one low |
| kind_o | output | 2 | 0 idle/undefined, 1 chip select, 2 DRAM, 3 default external |
| dram_idx_o | output | 1 | Index of the DRAM region hit |
| port_size_o | output | 2 | Static port-size code |
| bus_bytes_o | output | 3 | Port width in bytes |
| burst_en_o | output | 1 | Burst allowed for this access |
| undef_o | output | 1 | Undefined hit combination |

## Verification
The properties assume `req_valid` is a known level from the first clock after reset. They also assume the request address is held only for the cycle in which it is sampled, so every result depends on a single cycle's inputs. The bench drives all inputs at the falling edge, holds `req_valid` low during reset, and mixes register writes with requests. It places requests in the same cycle as a write and in the cycle after it. Region contents are chosen so that every row of the hit-count table, the boot override, and its permanent end are all reached.

// File: rtl/cs_cls_pkg.sv
package cs_cls_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_CS   = 2'd1,
    ACC_DRAM = 2'd2,
    ACC_EXT  = 2'd3
  } acc_kind_e;

  localparam int CTRL_W = 3;

  function automatic logic [2:0] bytes_of(input logic [1:0] ps);
    case (ps)
      2'b01:   bytes_of = 3'd1;
      2'b10:   bytes_of = 3'd2;
      default: bytes_of = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/cs_cls_regfile.sv
module cs_cls_regfile #(
  parameter int ADDR_W = 32,
  parameter int N_REG  = 6,
  parameter int RA_W   = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [RA_W-1:0]                    wr_addr,
  input  logic [ADDR_W-1:0]                  wr_data,
  output logic [N_REG-1:0][ADDR_W-1:0]       base_o,
  output logic [N_REG-1:0][ADDR_W-1:0]       mask_o,
  output logic [N_REG-1:0][cs_cls_pkg::CTRL_W-1:0] ctrl_o,
  output logic                               boot_o
);
  import cs_cls_pkg::*;

  localparam int RG_W = RA_W - 2;

  logic [N_REG-1:0][ADDR_W-1:0] base_q, base_d, mask_q, mask_d;
  logic [N_REG-1:0][CTRL_W-1:0] ctrl_q, ctrl_d;
  logic                         boot_q, boot_d;
  logic [RG_W-1:0]              wr_rgn;
  logic [1:0]                   wr_fld;

  assign wr_rgn = wr_addr[RA_W-1:2];
  assign wr_fld = wr_addr[1:0];

  always_comb begin
    base_d = base_q;
    mask_d = mask_q;
    ctrl_d = ctrl_q;
    boot_d = boot_q;
    for (int i = 0; i < N_REG; i++) begin
      if (wr_en && wr_rgn == RG_W'(i)) begin
        case (wr_fld)
          2'd0:    base_d[i] = wr_data;
          2'd1:    mask_d[i] = wr_data;
          2'd2:    ctrl_d[i] = wr_data[CTRL_W-1:0];
          default: ;
        endcase
      end
    end
    if (wr_en && wr_rgn == '0 && wr_fld == 2'd1 && wr_data[0])
      boot_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
      boot_q <= 1'b1;
    end else if (wr_en) begin
      base_q <= base_d;
      mask_q <= mask_d;
      ctrl_q <= ctrl_d;
      boot_q <= boot_d;
    end
  end

  assign base_o = base_q;
  assign mask_o = mask_q;
  assign ctrl_o = ctrl_q;
  assign boot_o = boot_q;

endmodule

// File: rtl/cs_cls_match.sv
module cs_cls_match #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  output logic              hit
);
  logic [ADDR_W-1:0] care;

  // bit 0 of the mask is the valid flag, so address bit 0 is never compared
  assign care = ~{mask[ADDR_W-1:1], 1'b1};
  assign hit  = mask[0] && (((addr ^ base) & care) == '0);

endmodule

// File: rtl/cs_cls_resolve.sv
module cs_cls_resolve #(
  parameter int N_CS = 4,
  parameter int N_DR = 2,
  parameter int DI_W = 1
) (
  input  logic                                   req_valid,
  input  logic                                   boot,
  input  logic [N_CS-1:0]                        cs_hit,
  input  logic [N_DR-1:0]                        dr_hit,
  input  logic [N_CS-1:0][cs_cls_pkg::CTRL_W-1:0] cs_ctrl,
  input  logic [N_DR-1:0][cs_cls_pkg::CTRL_W-1:0] dr_ctrl,
  output logic [N_CS-1:0]                        cs_n,
  output cs_cls_pkg::acc_kind_e                  kind,
  output logic [DI_W-1:0]                        dram_idx,
  output logic [1:0]                             port_size,
  output logic [2:0]                             bus_bytes,
  output logic                                   burst_en,
  output logic                                   undef
);
  import cs_cls_pkg::*;

  int unsigned n_cs, n_dr;
  logic [CTRL_W-1:0] sel_ctrl;

  assign n_cs = $countones(cs_hit);
  assign n_dr = $countones(dr_hit);

  always_comb begin
    cs_n      = '1;
    kind      = ACC_IDLE;
    dram_idx  = '0;
    sel_ctrl  = '0;
    undef     = 1'b0;
    port_size = 2'b00;
    bus_bytes = 3'd0;
    burst_en  = 1'b0;
    if (req_valid) begin
      if (boot) begin
        cs_n[0]  = 1'b0;
        kind     = ACC_CS;
        sel_ctrl = cs_ctrl[0];
      end else if (n_cs == 0 && n_dr == 0) begin
        kind = ACC_EXT;
      end else if (n_cs == 1 && n_dr == 0) begin
        kind = ACC_CS;
        for (int i = 0; i < N_CS; i++) begin
          if (cs_hit[i]) begin
            cs_n[i]  = 1'b0;
            sel_ctrl = cs_ctrl[i];
          end
        end
      end else if (n_cs == 0 && n_dr == 1) begin
        kind = ACC_DRAM;
        for (int j = 0; j < N_DR; j++) begin
          if (dr_hit[j]) begin
            dram_idx = DI_W'(j);
            sel_ctrl = dr_ctrl[j];
          end
        end
      end else begin
        undef = 1'b1;
      end
      if (kind == ACC_CS || kind == ACC_DRAM) begin
        port_size = sel_ctrl[1:0];
        burst_en  = sel_ctrl[2];
        bus_bytes = bytes_of(sel_ctrl[1:0]);
      end else if (kind == ACC_EXT) begin
        bus_bytes = 3'd4;
      end
    end
  end

endmodule

// File: rtl/cs_access_classifier.sv
module cs_access_classifier #(
  parameter int N_CS   = 4,
  parameter int N_DR   = 2,
  parameter int ADDR_W = 32,
  localparam int N_REG = N_CS + N_DR,
  localparam int RA_W  = $clog2(N_REG) + 2,
  localparam int DI_W  = (N_DR > 1) ? $clog2(N_DR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   wr_addr,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [N_CS-1:0]   cs_n_o,
  output logic [1:0]        kind_o,
  output logic [DI_W-1:0]   dram_idx_o,
  output logic [1:0]        port_size_o,
  output logic [2:0]        bus_bytes_o,
  output logic              burst_en_o,
  output logic              undef_o
);
  import cs_cls_pkg::*;

  // reset: asserted at once, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [N_REG-1:0][ADDR_W-1:0] base_w, mask_w;
  logic [N_REG-1:0][CTRL_W-1:0] ctrl_w;
  logic                         boot_mode;

  cs_cls_regfile #(.ADDR_W(ADDR_W), .N_REG(N_REG), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .base_o(base_w), .mask_o(mask_w), .ctrl_o(ctrl_w),
    .boot_o(boot_mode)
  );

  logic [N_REG-1:0] hit_w;
  for (genvar g = 0; g < N_REG; g++) begin : g_match
    cs_cls_match #(.ADDR_W(ADDR_W)) u_match (
      .addr(req_addr), .base(base_w[g]), .mask(mask_w[g]), .hit(hit_w[g])
    );
  end

  logic [N_CS-1:0][CTRL_W-1:0] cs_ctrl_w;
  logic [N_DR-1:0][CTRL_W-1:0] dr_ctrl_w;
  assign cs_ctrl_w = ctrl_w[N_CS-1:0];
  assign dr_ctrl_w = ctrl_w[N_REG-1:N_CS];

  logic [N_CS-1:0] cs_n_d;
  acc_kind_e       kind_d;
  logic [DI_W-1:0] dram_idx_d;
  logic [1:0]      port_size_d;
  logic [2:0]      bus_bytes_d;
  logic            burst_en_d, undef_d;

  cs_cls_resolve #(.N_CS(N_CS), .N_DR(N_DR), .DI_W(DI_W)) u_resolve (
    .req_valid(req_valid), .boot(boot_mode),
    .cs_hit(hit_w[N_CS-1:0]), .dr_hit(hit_w[N_REG-1:N_CS]),
    .cs_ctrl(cs_ctrl_w), .dr_ctrl(dr_ctrl_w),
    .cs_n(cs_n_d), .kind(kind_d), .dram_idx(dram_idx_d),
    .port_size(port_size_d), .bus_bytes(bus_bytes_d),
    .burst_en(burst_en_d), .undef(undef_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cs_n_o      <= '1;
      kind_o      <= ACC_IDLE;
      dram_idx_o  <= '0;
      port_size_o <= '0;
      bus_bytes_o <= '0;
      burst_en_o  <= 1'b0;
      undef_o     <= 1'b0;
    end else begin
      cs_n_o      <= cs_n_d;
      kind_o      <= kind_d;
      dram_idx_o  <= dram_idx_d;
      port_size_o <= port_size_d;
      bus_bytes_o <= bus_bytes_d;
      burst_en_o  <= burst_en_d;
      undef_o     <= undef_d;
    end
  end

endmodule

// File: rtl/cs_cls_checker.sv
module cs_cls_checker #(
  parameter int N_CS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            boot,
  input logic [N_CS-1:0] cs_n,
  input logic [1:0]      kind,
  input logic [1:0]      port_size,
  input logic            burst_en,
  input logic            undef
);
  localparam logic [N_CS-1:0] BOOT_PAT = ~(N_CS'(1));

  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R2
  boot_cs0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && boot) |=> (cs_n == BOOT_PAT && kind == 2'd1 && !undef));

  // R9
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (&cs_n && kind == 2'd0 && !undef));

  // R8
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (&cs_n && kind == 2'd0 && port_size == 2'b00 && !burst_en));

  // R5
  ext_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 2'd3) |-> (port_size == 2'b00 && !burst_en && &cs_n));

  // R7
  dram_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 2'd2) |-> (&cs_n && !undef));

  // R6
  cs_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 2'd1) == !(&cs_n));

endmodule

bind cs_access_classifier cs_cls_checker #(.N_CS(N_CS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .boot(boot_mode),
  .cs_n(cs_n_o), .kind(kind_o), .port_size(port_size_o),
  .burst_en(burst_en_o), .undef(undef_o)
);

// File: tb/cs_access_classifier_test.sv
`timescale 1ns/1ps
module cs_access_classifier_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  cs_n_o;
  logic [1:0]  kind_o;
  logic [0:0]  dram_idx_o;
  logic [1:0]  port_size_o;
  logic [2:0]  bus_bytes_o;
  logic        burst_en_o, undef_o;

  always #2.5 clk = ~clk;

  cs_access_classifier uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .req_valid(req_valid), .req_addr(req_addr),
    .cs_n_o(cs_n_o), .kind_o(kind_o), .dram_idx_o(dram_idx_o),
    .port_size_o(port_size_o), .bus_bytes_o(bus_bytes_o),
    .burst_en_o(burst_en_o), .undef_o(undef_o)
  );

  int errors = 0;
  int checks = 0;

  // behavioural model state
  logic [31:0] m_base [6];
  logic [31:0] m_mask [6];
  logic [2:0]  m_ctrl [6];
  bit          m_boot;

  logic [13:0] exp_q;
  string       exp_tag, scen_tag;
  bit          have_exp = 0;

  function automatic bit m_hit(int r, logic [31:0] a);
    return m_mask[r][0] && (((a ^ m_base[r]) & ~(m_mask[r] | 32'h1)) == 0);
  endfunction

  function automatic logic [2:0] m_bytes(logic [1:0] p);
    return (p == 2'b01) ? 3'd1 : (p == 2'b10) ? 3'd2 : 3'd4;
  endfunction

  // packing: {cs_n[3:0], kind[1:0], idx, port[1:0], bytes[2:0], burst, undef}
  task automatic m_eval(input bit rv, input logic [31:0] a,
                        output logic [13:0] e, output string t);
    int ncs = 0, ndr = 0, ci = 0, di = 0;
    logic [3:0] csn = 4'hF;
    logic [2:0] c;
    if (!rv) begin e = {4'hF, 10'd0}; t = "R9"; return; end
    if (m_boot) begin
      c = m_ctrl[0];
      e = {4'b1110, 2'd1, 1'b0, c[1:0], m_bytes(c[1:0]), c[2], 1'b0};
      t = "R2"; return;
    end
    for (int r = 0; r < 4; r++) if (m_hit(r, a)) begin ncs++; ci = r; end
    for (int r = 4; r < 6; r++) if (m_hit(r, a)) begin ndr++; di = r; end
    if (ncs == 0 && ndr == 0) begin
      e = {4'hF, 2'd3, 1'b0, 2'b00, 3'd4, 1'b0, 1'b0}; t = "R5";
    end else if (ncs == 1 && ndr == 0) begin
      c = m_ctrl[ci]; csn[ci] = 1'b0;
      e = {csn, 2'd1, 1'b0, c[1:0], m_bytes(c[1:0]), c[2], 1'b0}; t = "R6";
    end else if (ncs == 0 && ndr == 1) begin
      c = m_ctrl[di];
      e = {4'hF, 2'd2, 1'(di - 4), c[1:0], m_bytes(c[1:0]), c[2], 1'b0};
      t = "R7";
    end else begin
      e = {4'hF, 2'd0, 1'b0, 2'b00, 3'd0, 1'b0, 1'b1}; t = "R8";
    end
  endtask

  task automatic m_write(input int wa, input logic [31:0] wd);
    int rg = wa >> 2, fl = wa & 3;
    if (rg < 6) begin
      if (fl == 0) m_base[rg] = wd;
      if (fl == 1) m_mask[rg] = wd;
      if (fl == 2) m_ctrl[rg] = wd[2:0];
    end
    if (rg == 0 && fl == 1 && wd[0]) m_boot = 0;
  endtask

  task automatic compare();
    logic [13:0] act;
    act = {cs_n_o, kind_o, dram_idx_o, port_size_o, bus_bytes_o, burst_en_o, undef_o};
    checks++;
    if (act !== exp_q) begin
      errors++;
      $display("FAIL %s/%s: actual=%h expected=%h", scen_tag, exp_tag, act, exp_q);
    end
  endtask

  // one cycle: check previous cycle's result, then drive new inputs
  task automatic cyc(input bit we, input int wa, input logic [31:0] wd,
                     input bit rv, input logic [31:0] ra, input string tag);
    @(negedge clk);
    if (have_exp) compare();
    wr_en = we; wr_addr = 5'(wa); wr_data = wd;
    req_valid = rv; req_addr = ra;
    m_eval(rv, ra, exp_q, exp_tag);
    if (we) m_write(wa, wd);
    scen_tag = tag;
    have_exp = 1;
  endtask

  task automatic wr(input int rg, input int fl, input logic [31:0] d, input string tag);
    cyc(1, rg * 4 + fl, d, 0, 0, tag);
  endtask

  task automatic rq(input logic [31:0] a, input string tag);
    cyc(0, 0, 0, 1, a, tag);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < 6; r++) begin m_base[r] = 0; m_mask[r] = 0; m_ctrl[r] = 0; end
    m_boot = 1;
    // R1: outputs idle during and after reset
    repeat (3) @(negedge clk);
    exp_q = {4'hF, 10'd0}; exp_tag = "R1"; scen_tag = "R1";
    compare();
    rst_n = 1'b1;
    repeat (4) cyc(0, 0, 0, 0, 0, "R1");

    // R2: boot override ignores address and other regions
    rq(32'h8000_0000, "R2");
    wr(0, 2, 32'h1, "R2");
    wr(1, 0, 32'h1000_0000, "R2");
    wr(1, 1, 32'h00FF_FFFF, "R2");
    wr(1, 2, 32'h6, "R2");
    wr(4, 0, 32'h4000_0000, "R2");
    wr(4, 1, 32'h0FFF_FFFF, "R2");
    wr(4, 2, 32'h4, "R2");
    rq(32'h1000_0010, "R2");
    rq(32'h4000_0000, "R2");
    rq(32'hFFFF_FFFE, "R2");
    wr(0, 1, 32'h0000_FFFE, "R2"); // valid bit 0: still boot
    rq(32'h1000_0010, "R2");
    cyc(0, 0, 0, 0, 0, "R9");

    // R3: set cs0 valid, then normal decode
    wr(0, 0, 32'h0, "R3");
    cyc(1, 1, 32'h0000_FFFF, 1, 32'h1000_0010, "R3"); // same-cycle request still boot
    rq(32'h0000_1000, "R3");
    rq(32'h1000_0010, "R3");
    rq(32'h8000_0000, "R3");

    // remaining regions
    wr(2, 0, 32'h2000_0000, "R11"); wr(2, 1, 32'h0000_0FFF, "R11"); wr(2, 2, 32'h2, "R11");
    wr(3, 0, 32'h2000_0000, "R11"); wr(3, 1, 32'h000F_FFFF, "R11"); wr(3, 2, 32'h3, "R11");
    wr(5, 0, 32'h4800_0000, "R11"); wr(5, 1, 32'h00FF_FFFF, "R11"); wr(5, 2, 32'h5, "R11");
    rq(32'h2001_0000, "R6");
    rq(32'h2000_0010, "R8");   // two chip selects
    rq(32'h4000_0000, "R7");
    rq(32'h4800_0000, "R8");   // two DRAM regions
    rq(32'h9000_0000, "R5");
    // R4: bit 0 ignored, edges of the masked window
    rq(32'h1000_0011, "R4");
    rq(32'h10FF_FFFF, "R4");
    rq(32'h1100_0000, "R4");
    rq(32'h0FFF_FFFF, "R4");
    // R11: field 3 and out-of-range region writes change nothing
    wr(1, 3, 32'h0, "R11");
    wr(6, 1, 32'hFFFF_FFFF, "R11");
    wr(7, 2, 32'h7, "R11");
    rq(32'h1000_0020, "R11");
    rq(32'hC000_0000, "R11");
    // R10: write and request in the same cycle, then next cycle
    cyc(1, 1 * 4 + 2, 32'h1, 1, 32'h1000_0040, "R10");
    rq(32'h1000_0040, "R10");
    cyc(0, 0, 0, 0, 0, "R9");
    // one chip select with multiple DRAM hits
    wr(1, 0, 32'h4800_0000, "R8");
    rq(32'h4800_0100, "R8");
    // one chip select and one DRAM
    rq(32'h4000_0100, "R8");   // no chip select here: DRAM only
    wr(3, 0, 32'h4100_0000, "R8");
    rq(32'h4101_0000, "R8");   // cs3 + dram0
    // multiple chip selects with one DRAM hit
    wr(2, 0, 32'h4100_0000, "R8");
    rq(32'h4100_0010, "R8");
    // multiple both
    wr(2, 0, 32'h4800_0000, "R8");
    rq(32'h4800_0010, "R8");
    // second DRAM alone
    wr(4, 1, 32'h0, "R7");
    wr(1, 1, 32'h0, "R7");
    wr(2, 1, 32'h0, "R7");
    rq(32'h4812_3456, "R7");
    // R3: clearing cs0 valid does not restore boot override
    wr(0, 1, 32'h0000_FFFE, "R3");
    rq(32'h0000_1000, "R3");
    rq(32'h2010_0000, "R3");
    repeat (2) cyc(0, 0, 0, 0, 0, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule